// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a 16-bit offset into a 20-bit physical address. It holds four 16-bit segment registers: code, data, stack and extra. Each request carries an offset, a code that names the base register the offset came from, and an optional segment override. The block picks a segment register from the base code, or from the override when the override is allowed. It shifts that segment left by four bits, adds the offset and registers the result.

Because the segment is shifted by four bits, every segment starts on a 16-byte boundary and covers 64 KB. A carry out of the top address bit is dropped, so addresses wrap inside the 1 MB space. A write port loads the segment registers. A write is seen by requests issued in the cycle after the write and not by a request in the same cycle.

Top module: `seg_agu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `addr_valid` and `addr_out` are cleared. The code segment register resets to parameter `CODE_RESET` (default 16'hFFFF), and the data, stack and extra registers reset to zero.
- R2: A request with base code 0 (instruction pointer) uses the code segment, whatever the override inputs are.
- R3: A request with base code 1 (stack pointer) or 2 (base pointer) and no override uses the stack segment.
- R4: A request with base code 3 (BX), 4 (direct address), 5 (source index) or 7 (spare) and no override uses the data segment.
- R5: A request with base code 6 (string destination index) uses the extra segment, whatever the override inputs are.
- R6: When `ovr_valid` is high, base codes 1, 2, 3, 4, 5 and 7 use the segment named by `ovr_seg` instead of the default. When `ovr_valid` is low, `ovr_seg` has no effect.
- R7: The address is the selected segment multiplied by 16 plus the zero-extended offset, taken modulo 2^20.
- R8: `addr_valid` is high exactly in the cycle after a cycle with `req_valid` high. `addr_out` changes only on such results and otherwise holds its last value.
- R9: When `wr_en` is high, `wr_data` is written to the register named by `wr_sel`. A request in the same cycle still uses the old value, and a request in the next cycle uses the new one.

Segment selector encoding for both `wr_sel` and `ovr_seg`: 0 = code, 1 = data, 2 = stack, 3 = extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request present |
| req_base | input | 3 | Base register code of the request (0 to 7, see R2 to R5) |
| req_off | input | 16 | Offset of the request |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Segment selected by the override |
| addr_valid | output | 1 | Registered address is new this cycle |
| addr_out | output | 20 | Registered physical address |

## Verification
The bench targets the following corner cases:
- **Write and request in the same cycle.** A design that forwards the write would return the new segment one cycle too early.
- **Overrides on fetches and string destinations.** A design that lets the override win here would send these accesses to the data or stack area.
- **Large segment plus large offset.** A design that keeps the carry, or that adds the offset into the wrong bits, would give an address outside the 1 MB space or a shifted address.
- **Idle cycles and reset in mid-run.** A design that does not hold `addr_out` during idle cycles, or that does not restore the reset values, would be caught by the cycle-by-cycle model comparison.

// File: rtl/seg_agu_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the segmented address generation unit.
// Assumes a four-register segment file and a three-bit base code.
package seg_agu_pkg;

    localparam int NUM_SEGS = 4;
    localparam int SEL_W    = $clog2(NUM_SEGS);

    // Segment register identifiers (also the write and override selector).
    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    // Base register code carried by a request.
    typedef enum logic [2:0] {
        BASE_IP     = 3'd0,
        BASE_SP     = 3'd1,
        BASE_BP     = 3'd2,
        BASE_BX     = 3'd3,
        BASE_DIRECT = 3'd4,
        BASE_SI     = 3'd5,
        BASE_DI_STR = 3'd6,
        BASE_SPARE  = 3'd7
    } base_e;

    // Default segment for a base code when no override applies.
    function automatic seg_id_e default_seg(input base_e b);
        case (b)
            BASE_IP:          return SEG_CODE;
            BASE_SP, BASE_BP: return SEG_STACK;
            BASE_DI_STR:      return SEG_EXTRA;
            default:          return SEG_DATA;
        endcase
    endfunction

    // Fetches and string destinations keep their segment under an override.
    function automatic logic override_ok(input base_e b);
        return (b != BASE_IP) && (b != BASE_DI_STR);
    endfunction

endpackage

// File: rtl/seg_agu_regfile.sv
`timescale 1ns/1ps
// Module: segment register file.
// Holds NUM_SEGS registers of SEG_W bits. One write per cycle through a
// single port. The register contents are presented flattened, with entry 0
// in the least significant slice. The code register (entry 0) resets to
// CODE_RESET and the others reset to zero. There is no write forwarding:
// a reader sees a write in the cycle after the write.
module seg_agu_regfile #(
    parameter int SEG_W      = 16,
    parameter int NUM_SEGS   = 4,
    parameter logic [SEG_W-1:0] CODE_RESET = '1,
    localparam int SEL_W     = $clog2(NUM_SEGS),
    localparam int FLAT_W    = NUM_SEGS * SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    output logic [FLAT_W-1:0] seg_flat
);

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL = (g == 0) ? CODE_RESET : '0;
        logic [SEG_W-1:0] seg_q;

        // Load this register on a matching write, restore it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q <= RST_VAL;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                seg_q <= wr_data;
            end
        end

        assign seg_flat[g*SEG_W +: SEG_W] = seg_q;
    end

endmodule

// File: rtl/seg_agu_select.sv
`timescale 1ns/1ps
// Module: segment selection.
// Picks the segment register for a request. The default comes from the base
// code. An override replaces the default except for instruction fetches and
// string destinations. Purely combinational.
module seg_agu_select
    import seg_agu_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int NUM_SEGS = 4,
    localparam int SEL_W   = $clog2(NUM_SEGS),
    localparam int FLAT_W  = NUM_SEGS * SEG_W
) (
    input  logic [2:0]        req_base,
    input  logic              ovr_valid,
    input  logic [SEL_W-1:0]  ovr_seg,
    input  logic [FLAT_W-1:0] seg_flat,
    output logic [SEG_W-1:0]  seg_val
);

    base_e            base;
    logic [SEL_W-1:0] seg_pick;

    assign base = base_e'(req_base);

    // Choose the segment: the override wins where the access kind permits it.
    always_comb begin
        if (ovr_valid && override_ok(base)) begin
            seg_pick = ovr_seg;
        end else begin
            seg_pick = SEL_W'(default_seg(base));
        end
    end

    // Read the chosen register out of the flattened file.
    always_comb begin
        seg_val = seg_flat[seg_pick*SEG_W +: SEG_W];
    end

endmodule

// File: rtl/seg_agu_adder.sv
`timescale 1ns/1ps
// Module: shift-and-add address former.
// Computes seg * 2^SHIFT + off, modulo 2^(SEG_W+SHIFT). The low SHIFT bits
// of the offset pass straight through. Only SEG_W bits need an adder, and
// the carry out of the top is dropped. Assumes OFF_W - SHIFT <= SEG_W.
module seg_agu_adder #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);

    if (SHIFT > 0) begin : g_split
        logic [SEG_W-1:0] hi_sum;

        // Add the offset's upper part to the segment; low bits bypass.
        always_comb begin
            hi_sum = seg + SEG_W'(off[OFF_W-1:SHIFT]);
            addr   = {hi_sum, off[SHIFT-1:0]};
        end
    end else begin : g_flat
        // No shift: a plain wrapped addition.
        always_comb begin
            addr = seg + SEG_W'(off);
        end
    end

endmodule

// File: rtl/seg_agu.sv
`timescale 1ns/1ps
// Module: segmented address generation unit (top).
// Segment register file, segment selection and shift-and-add, with one
// output register stage. A request presented in cycle N gives addr_valid and
// addr_out in cycle N+1. addr_out holds its value between results.
// Synchronous active-low reset.
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter logic [SEG_W-1:0] CODE_RESET = 16'hFFFF,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int FLAT_W = NUM_SEGS * SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [2:0]        req_base,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              ovr_valid,
    input  logic [SEL_W-1:0]  ovr_seg,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out
);

    logic [FLAT_W-1:0] seg_flat;
    logic [SEG_W-1:0]  seg_val;
    logic [ADDR_W-1:0] addr_next;

    seg_agu_regfile #(
        .SEG_W      (SEG_W),
        .NUM_SEGS   (NUM_SEGS),
        .CODE_RESET (CODE_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .seg_flat (seg_flat)
    );

    seg_agu_select #(
        .SEG_W    (SEG_W),
        .NUM_SEGS (NUM_SEGS)
    ) u_sel (
        .req_base  (req_base),
        .ovr_valid (ovr_valid),
        .ovr_seg   (ovr_seg),
        .seg_flat  (seg_flat),
        .seg_val   (seg_val)
    );

    seg_agu_adder #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_add (
        .seg  (seg_val),
        .off  (req_off),
        .addr (addr_next)
    );

    // Register the valid flag every cycle; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= req_valid;
        end
    end

    // Capture the formed address only when a request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (req_valid) begin
            addr_out <= addr_next;
        end
    end

endmodule

// File: rtl/seg_agu_chk.sv
`timescale 1ns/1ps
// Module: property checker for seg_agu, attached with bind.
// Watches the ports and the flattened segment file.
module seg_agu_chk #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter logic [SEG_W-1:0] CODE_RESET = 16'hFFFF,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int FLAT_W = 4 * SEG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [SEG_W-1:0]  wr_data,
    input logic              req_valid,
    input logic [2:0]        req_base,
    input logic [OFF_W-1:0]  req_off,
    input logic              ovr_valid,
    input logic [1:0]        ovr_seg,
    input logic [FLAT_W-1:0] seg_flat,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_out
);

    function automatic logic [SEG_W-1:0] seg_of(input logic [FLAT_W-1:0] f, input logic [1:0] id);
        return f[id*SEG_W +: SEG_W];
    endfunction

    function automatic logic [ADDR_W-1:0] phys(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o);
        return {s, {SHIFT{1'b0}}} + ADDR_W'(o);
    endfunction

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!addr_valid && seg_of(seg_flat, 2'd0) == CODE_RESET
                           && seg_of(seg_flat, 2'd1) == '0));

    assert_fetch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_base == 3'd0) |=>
            addr_out == phys(seg_of($past(seg_flat), 2'd0), $past(req_off)));

    assert_stack_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_valid && (req_base == 3'd1 || req_base == 3'd2)) |=>
            addr_out == phys(seg_of($past(seg_flat), 2'd2), $past(req_off)));

    assert_data_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_valid && (req_base == 3'd3 || req_base == 3'd4 ||
                                     req_base == 3'd5 || req_base == 3'd7)) |=>
            addr_out == phys(seg_of($past(seg_flat), 2'd1), $past(req_off)));

    assert_string_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_base == 3'd6) |=>
            addr_out == phys(seg_of($past(seg_flat), 2'd3), $past(req_off)));

    assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid && req_base != 3'd0 && req_base != 3'd6) |=>
            addr_out == phys(seg_of($past(seg_flat), $past(ovr_seg)), $past(req_off)));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(addr_out)));

    assert_write_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_of(seg_flat, $past(wr_sel)) == $past(wr_data));

endmodule

bind seg_agu seg_agu_chk #(
    .SEG_W      (SEG_W),
    .OFF_W      (OFF_W),
    .SHIFT      (SHIFT),
    .CODE_RESET (CODE_RESET)
) u_chk (.*);

// File: tb/seg_agu_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the outputs on every cycle.
module seg_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [2:0]  req_base;
    logic [15:0] req_off;
    logic        ovr_valid;
    logic [1:0]  ovr_seg;
    logic        addr_valid;
    logic [19:0] addr_out;

    int unsigned mseg[4];
    logic        exp_valid;
    int unsigned exp_addr;
    int          vectors = 0;
    int          errs    = 0;
    bit          done    = 0;

    always #2.5 clk = ~clk;

    seg_agu u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_base(req_base), .req_off(req_off),
        .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    function automatic int pick(input int b, input bit ov, input int os);
        if (b == 0) return 0;
        if (b == 6) return 3;
        if (ov) return os;
        if (b == 1 || b == 2) return 2;
        return 1;
    endfunction

    function automatic string auto_tag(input int b, input bit ov);
        if (b == 0) return "R2";
        if (b == 6) return "R5";
        if (ov) return "R6";
        if (b == 1 || b == 2) return "R3";
        return "R4";
    endfunction

    // One cycle: drive at negedge, update model, compare at the next negedge.
    task automatic step(input bit rst, input bit we, input int ws, input int wd,
                        input bit rv, input int b, input int off,
                        input bit ov, input int os, input string tag);
        rst_n = !rst; wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd);
        req_valid = rv; req_base = 3'(b); req_off = 16'(off);
        ovr_valid = ov; ovr_seg = 2'(os);
        if (rst) begin
            exp_valid = 1'b0; exp_addr = 0;
            mseg[0] = 32'hFFFF; mseg[1] = 0; mseg[2] = 0; mseg[3] = 0;
        end else begin
            exp_valid = rv;
            if (rv) exp_addr = ((mseg[pick(b, ov, os)] * 16) + (off & 32'hFFFF)) % (1 << 20);
            if (we) mseg[ws] = wd & 32'hFFFF;
        end
        @(negedge clk);
        vectors++;
        if (addr_valid !== exp_valid) begin
            errs++;
            $display("FAIL %s addr_valid actual %b expected %b", tag, addr_valid, exp_valid);
        end
        vectors++;
        if (addr_out !== 20'(exp_addr)) begin
            errs++;
            $display("FAIL %s addr_out actual %05h expected %05h", tag, addr_out, exp_addr);
        end
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; req_valid = 0;
        req_base = 0; req_off = 0; ovr_valid = 0; ovr_seg = 0;
        @(negedge clk);
        // R1 reset state and reset code segment value.
        step(1, 0, 0, 0, 1, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 1, 0, 16'h0000, 0, 0, "R1");
        // R9: same-cycle write not seen, next cycle seen.
        step(0, 1, 1, 16'h1234, 1, 3, 16'h0300, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 3, 16'h0300, 0, 0, "R9");
        // R4 other data-default bases.
        step(0, 0, 0, 0, 1, 4, 16'h0310, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 5, 16'hABCD, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 7, 16'h0001, 0, 0, "R4");
        // R3 stack bases.
        step(0, 1, 2, 16'h5000, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 1, 16'h0010, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 2, 16'hFFFE, 0, 0, "R3");
        // R5 string destination, override ignored.
        step(0, 1, 3, 16'hA000, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 6, 16'h0002, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 6, 16'h0002, 1, 1, "R5");
        // R2 fetch, override ignored.
        step(0, 1, 0, 16'h348A, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 0, 16'h0012, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 0, 16'h0012, 1, 2, "R2");
        // R6 override applied / inactive override ignored.
        step(0, 0, 0, 0, 1, 3, 16'h0040, 1, 3, "R6");
        step(0, 0, 0, 0, 1, 1, 16'h0040, 1, 1, "R6");
        step(0, 0, 0, 0, 1, 2, 16'h0040, 1, 0, "R6");
        step(0, 0, 0, 0, 1, 3, 16'h0040, 0, 3, "R6");
        // R7 wrap past the 1 MB space, and the top address without wrap.
        step(0, 1, 1, 16'hFFFF, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 3, 16'hFFFF, 0, 0, "R7");
        step(0, 1, 1, 16'hF000, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 3, 16'hFFFF, 0, 0, "R7");
        // R8 idle cycles hold the address.
        step(0, 0, 0, 0, 0, 3, 16'h1111, 1, 2, "R8");
        step(0, 0, 0, 0, 0, 0, 16'h2222, 0, 0, "R8");
        // R1 reset in mid-run restores the register values.
        step(1, 0, 0, 0, 1, 3, 16'h0005, 0, 0, "R1");
        step(0, 0, 0, 0, 1, 3, 16'h0005, 0, 0, "R1");
        step(0, 0, 0, 0, 1, 0, 16'h0005, 0, 0, "R1");
        // Random traffic checked against the model.
        for (int i = 0; i < 600; i++) begin
            int b = int'($urandom_range(0, 7));
            bit ov = 1'($urandom_range(0, 1));
            bit rst = ($urandom_range(0, 99) == 0);
            step(rst, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 16'hFFFF)), 1'($urandom_range(0, 3) != 0),
                 b, int'($urandom_range(0, 16'hFFFF)), ov, int'($urandom_range(0, 3)),
                 rst ? "R1" : auto_tag(b, ov));
        end
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

endmodule